// File: doc/BRIEF.md
# Binary-search top-of-memory finder

This block works out how far a contiguous RAM reaches above a base address. It settles the answer one address bit at a time, by successive approximation instead of a linear scan. A running top-of-RAM offset starts at zero. For each bit, from a configurable highest bit down to bit 2, the block forms two candidate addresses: the base plus the current offset, and the base plus the current offset with the bit under test added. If both candidates are allowed RAM and hold independent data, the bit is kept in the offset. If they alias, or either one falls outside the allowed region, the bit stays clear. Because the lowest bit probed is bit 2, the result always has 32-bit word granularity.

Before any memory access, the block asks the system about each candidate through a region query port. It then runs an independence probe over a request/acknowledge master port. The probe writes a pattern to one address and its complement to the other, reads both back, and then repeats with the roles swapped. The probe stops at the first read that does not match. A one-cycle done pulse marks the end of a search. The result stays on its output until the next start.

Top module: `memtop_search`

## Requirements
- R1: After reset, `done` and `mem_req` are low and `top_offset` is zero.
- R2: A `start` accepted while idle clears `top_offset` to zero. Bits TOP_BIT down to 2 are then decided in that order, and bits 1:0 of the result are always zero. For RAM that repeats every 2^k bytes with every address allowed, the result is 2^k - 4.
- R3: For bit b with current offset T, the low candidate is `base_addr` + T and the high candidate is `base_addr` + T + 2^b (modulo 2^ADDR_W). Every memory access goes to one of these two addresses.
- R4: The low candidate and then the high candidate are presented on `region_addr`, and `region_ok` is sampled for each. If either is refused, the bit stays 0 and no memory access is made for that bit. If the allowed region is [base, base+E), with E a multiple of 4 that lies within non-aliasing RAM, the result is E - 4.
- R5: The probe for one bit makes up to eight accesses, in this order, with P = PATTERN (default 32'hA5C3_0F69): write P to low, write ~P to high, read low, read high, write ~P to low, write P to high, read low, read high. A bit is set only when all four reads return the value last written to that address.
- R6: The probe ends at the first read that mismatches, and that bit stays 0. With every address allowed and RAM repeating every 4 KiB, a search with TOP_BIT = 31 makes exactly 140 accesses, 80 of them writes.
- R7: `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until `mem_ack` is seen. Only one access is outstanding at a time, and the search is correct for any acknowledge latency.
- R8: `done` is high for exactly one cycle per search. `top_offset` holds its value while idle until the next accepted start.
- R9: `start` is ignored while a search runs. A `start` presented in the cycle `done` is high is accepted and begins a new search.
- R10: An address line that is not decoded (aliasing at one bit position) leaves exactly that bit clear in the result.
- R11: A data bit stuck at a constant value makes every probe fail, giving a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a search (accepted only while idle) |
| done | output | 1 | One-cycle pulse when the search ends |
| base_addr | input | ADDR_W | Offset added to every candidate address |
| region_addr | output | ADDR_W | Candidate address being checked against the allowed region |
| region_ok | input | 1 | High when `region_addr` may hold RAM (combinational answer) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Access complete; read data valid in the same cycle |
| mem_rdata | input | DATA_W | Read data |
| top_offset | output | ADDR_W | Found offset of the last RAM word above the base |

## Verification
A search can finish in the very cycle in which a new one is requested. The start pulse is raised in the cycle where `done` is high, and the allowed region is changed at the same moment. This is judged by seeing `top_offset` cleared on the next cycle and a second done pulse with the result for the new region. The reverse case is also run: a start arriving mid-search must leave the search length identical to a reference run with no extra start.

// File: rtl/memtop_pkg.sv
// Package: shared state encodings for the top-of-memory finder.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package memtop_pkg;

    // Controller states of the bit-by-bit search
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_CHK_LO = 3'd1,
        S_CHK_HI = 3'd2,
        S_PROBE  = 3'd3,
        S_NEXT   = 3'd4
    } ctl_state_t;

    // Probe sequencer states
    typedef enum logic [1:0] {
        P_IDLE  = 2'd0,
        P_ISSUE = 2'd1,
        P_WAIT  = 2'd2
    } probe_state_t;

endpackage

// File: rtl/memtop_addr_gen.sv
// Candidate address former.
// Builds the low and high candidate addresses for the bit under test from
// the running offset and the base, and picks which one goes to the region
// query. Assumes bit_idx < AW. Purely combinational.
module memtop_addr_gen #(
    parameter int AW = 32,
    parameter int BW = $clog2(AW)
) (
    input  logic [AW-1:0] top_val,
    input  logic [BW-1:0] bit_idx,
    input  logic [AW-1:0] base,
    input  logic          sel_hi,
    output logic [AW-1:0] bit_mask,
    output logic [AW-1:0] lo_addr,
    output logic [AW-1:0] hi_addr,
    output logic [AW-1:0] region_addr
);

    // One-hot mask for the bit under test
    always_comb bit_mask = AW'(1) << bit_idx;

    // Both candidates share the base offset; the high one adds the bit
    always_comb begin
        lo_addr = base + (top_val & ~bit_mask);
        hi_addr = base + (top_val | bit_mask);
    end

    // Region query address follows the controller's check phase
    always_comb region_addr = sel_hi ? hi_addr : lo_addr;

endmodule

// File: rtl/memtop_bus.sv
// Single-outstanding request/acknowledge master.
// Latches one operation per op_valid pulse, holds mem_req with stable
// address and data until mem_ack, then returns a one-cycle op_done with
// the captured read data. Assumes op_valid never arrives while busy.
module memtop_bus #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic          op_we,
    input  logic [AW-1:0] op_addr,
    input  logic [DW-1:0] op_wdata,
    output logic          op_done,
    output logic [DW-1:0] op_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);

    // Request register: load on op_valid, retire on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            op_done   <= 1'b0;
            op_rdata  <= '0;
        end else begin
            op_done <= 1'b0;
            if (op_valid) begin
                mem_req   <= 1'b1;
                mem_we    <= op_we;
                mem_addr  <= op_addr;
                mem_wdata <= op_wdata;
            end else if (mem_req && mem_ack) begin
                mem_req  <= 1'b0;
                op_done  <= 1'b1;
                op_rdata <= mem_rdata;
            end
        end
    end

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    // R7
    single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> !mem_req);

endmodule

// File: rtl/memtop_probe.sv
// Two-address independence probe.
// On go, runs up to eight accesses on the low and high candidates:
// pattern then complement, read both, then swapped, read both. Stops at the
// first mismatching read. Reports a one-cycle done with pass held after.
// Assumes lo_addr/hi_addr stay constant while the probe runs.
module memtop_probe
    import memtop_pkg::*;
#(
    parameter int          AW      = 32,
    parameter int          DW      = 32,
    parameter logic [DW-1:0] PATTERN = 32'hA5C3_0F69
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] lo_addr,
    input  logic [AW-1:0] hi_addr,
    input  logic          op_done,
    input  logic [DW-1:0] op_rdata,
    output logic          op_valid,
    output logic          op_we,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_wdata,
    output logic          done,
    output logic          pass
);

    localparam int LAST_STEP = 7;

    probe_state_t pstate;
    logic [2:0]   step;

    // Step decode: bit0 picks address, bit1 picks read, bit0^bit2 inverts data
    always_comb begin
        op_valid = (pstate == P_ISSUE);
        op_we    = ~step[1];
        op_addr  = step[0] ? hi_addr : lo_addr;
        op_wdata = (step[0] ^ step[2]) ? ~PATTERN : PATTERN;
    end

    // Sequencer: issue, wait, compare, advance or stop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pstate <= P_IDLE;
            step   <= '0;
            done   <= 1'b0;
            pass   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (pstate)
                P_IDLE: begin
                    if (go) begin
                        step   <= '0;
                        pstate <= P_ISSUE;
                    end
                end
                P_ISSUE: pstate <= P_WAIT;
                P_WAIT: begin
                    if (op_done) begin
                        if (!op_we && (op_rdata != op_wdata)) begin
                            done   <= 1'b1;
                            pass   <= 1'b0;
                            pstate <= P_IDLE;
                        end else if (step == 3'(LAST_STEP)) begin
                            done   <= 1'b1;
                            pass   <= 1'b1;
                            pstate <= P_IDLE;
                        end else begin
                            step   <= step + 3'd1;
                            pstate <= P_ISSUE;
                        end
                    end
                end
                default: pstate <= P_IDLE;
            endcase
        end
    end

    // R5
    pass_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pass) |-> (step == 3'(LAST_STEP)));

    // R6
    early_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate == P_WAIT && op_done && !op_we && op_rdata != op_wdata)
            |=> (done && !pass && pstate == P_IDLE));

endmodule

// File: rtl/memtop_search.sv
// Top-of-memory finder, top level.
// Runs a successive-approximation search over address bits TOP_BIT..2.
// For each bit it queries the region for both candidates, runs the
// independence probe if both are allowed, and keeps the bit on success.
// Assumes 2 <= TOP_BIT < ADDR_W and a combinational region_ok answer.
module memtop_search
    import memtop_pkg::*;
#(
    parameter int            ADDR_W  = 32,
    parameter int            DATA_W  = 32,
    parameter int            TOP_BIT = 31,
    parameter logic [DATA_W-1:0] PATTERN = 32'hA5C3_0F69
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              done,
    input  logic [ADDR_W-1:0] base_addr,
    output logic [ADDR_W-1:0] region_addr,
    input  logic              region_ok,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] top_offset
);

    localparam int BW      = $clog2(ADDR_W);
    localparam int LOW_BIT = 2;

    ctl_state_t        state;
    logic [ADDR_W-1:0] top_q;
    logic [BW-1:0]     bit_q;
    logic              ok_q;
    logic              done_q;

    logic [ADDR_W-1:0] bit_mask, lo_addr, hi_addr;
    logic              probe_go, probe_done, probe_pass;
    logic              op_valid, op_we, op_done;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] op_wdata, op_rdata;

    memtop_addr_gen #(.AW(ADDR_W), .BW(BW)) u_addr (
        .top_val     (top_q),
        .bit_idx     (bit_q),
        .base        (base_addr),
        .sel_hi      (state == S_CHK_HI),
        .bit_mask    (bit_mask),
        .lo_addr     (lo_addr),
        .hi_addr     (hi_addr),
        .region_addr (region_addr)
    );

    // Probe launches once the high candidate is also accepted
    always_comb probe_go = (state == S_CHK_HI) && region_ok;

    memtop_probe #(.AW(ADDR_W), .DW(DATA_W), .PATTERN(PATTERN)) u_probe (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (probe_go),
        .lo_addr  (lo_addr),
        .hi_addr  (hi_addr),
        .op_done  (op_done),
        .op_rdata (op_rdata),
        .op_valid (op_valid),
        .op_we    (op_we),
        .op_addr  (op_addr),
        .op_wdata (op_wdata),
        .done     (probe_done),
        .pass     (probe_pass)
    );

    memtop_bus #(.AW(ADDR_W), .DW(DATA_W)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_we     (op_we),
        .op_addr   (op_addr),
        .op_wdata  (op_wdata),
        .op_done   (op_done),
        .op_rdata  (op_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata)
    );

    // Search controller: region checks, probe, bit decision, completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            top_q  <= '0;
            bit_q  <= BW'(TOP_BIT);
            ok_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        top_q <= '0;
                        bit_q <= BW'(TOP_BIT);
                        state <= S_CHK_LO;
                    end
                end
                S_CHK_LO: begin
                    if (region_ok) begin
                        state <= S_CHK_HI;
                    end else begin
                        ok_q  <= 1'b0;
                        state <= S_NEXT;
                    end
                end
                S_CHK_HI: begin
                    if (region_ok) begin
                        state <= S_PROBE;
                    end else begin
                        ok_q  <= 1'b0;
                        state <= S_NEXT;
                    end
                end
                S_PROBE: begin
                    if (probe_done) begin
                        ok_q  <= probe_pass;
                        state <= S_NEXT;
                    end
                end
                S_NEXT: begin
                    if (ok_q) top_q <= top_q | bit_mask;
                    if (bit_q == BW'(LOW_BIT)) begin
                        done_q <= 1'b1;
                        state  <= S_IDLE;
                    end else begin
                        bit_q <= bit_q - BW'(1);
                        state <= S_CHK_LO;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Result and completion outputs come straight from registers
    always_comb begin
        done       = done_q;
        top_offset = top_q;
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !start) |=> $stable(top_offset));

    // R4
    bus_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (state == S_PROBE));

    // R2
    low_bits_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |-> ((top_q & (bit_mask - ADDR_W'(1))) == '0));

    // R3
    addr_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr == lo_addr || mem_addr == hi_addr));

endmodule

// File: tb/memtop_search_test.sv
`timescale 1ns/1ps
module memtop_search_test;

    localparam logic [31:0] PAT = 32'hA5C3_0F69;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        done;
    logic [31:0] base_v = '0;
    logic [31:0] region_addr;
    logic        region_ok;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] top_offset;

    logic [32:0] region_end = 33'h1_0000_0000;
    logic [9:0]  alias_mask = 10'h3FF;
    logic [31:0] stuck_mask = 32'hFFFF_FFFF;
    bit          lat_mode = 1'b0;
    logic [31:0] mem [0:1023];

    int checks = 0, errors = 0;
    int nacc = 0, nwr = 0, bad_acc = 0, wait_cnt = 0;
    int ref_cycles = 0;

    always #4 clk = ~clk;

    assign region_ok = ({1'b0, region_addr - base_v} < region_end);

    memtop_search uut (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done),
        .base_addr(base_v), .region_addr(region_addr), .region_ok(region_ok),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .top_offset(top_offset)
    );

    // memory model: 4 KiB repeating, optional alias mask, stuck data bits
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (wait_cnt > 0) begin
                    wait_cnt--;
                end else begin
                    logic [31:0] off;
                    logic [9:0]  idx;
                    off = mem_addr - base_v;
                    idx = off[11:2] & alias_mask;
                    nacc++;
                    if (({1'b0, off} >= region_end) || (mem_addr[1:0] != 2'b00))
                        bad_acc++;
                    if (mem_we) begin
                        nwr++;
                        mem[idx] = mem_wdata & stuck_mask;
                    end else begin
                        mem_rdata = mem[idx];
                    end
                    mem_ack = 1'b1;
                    wait_cnt = lat_mode ? (nacc % 3) : 0;
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: run did not end (actual timeout, expected completion)");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic setup(input logic [31:0] b, input logic [32:0] e,
                         input logic [9:0] am, input logic [31:0] sm, input bit lat);
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        base_v = b; region_end = e; alias_mask = am; stuck_mask = sm; lat_mode = lat;
        wait_cnt = 0;
    endtask

    task automatic do_run(input int restart_at, output int cycles, output bit got);
        nacc = 0; nwr = 0; bad_acc = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        cycles = 0; got = 1'b0;
        while (!got && cycles < 20000) begin
            start = (restart_at > 0 && cycles == restart_at);
            @(negedge clk);
            cycles++;
            if (done) got = 1'b1;
        end
        start = 1'b0;
    endtask

    task automatic after_done(input string req);
        @(negedge clk);
        check(done == 1'b0, req, 32'(done), 32'd0, "done longer than one cycle");
    endtask

    task automatic t_reset();
        check(done == 1'b0, "R1", 32'(done), 0, "done after reset");
        check(mem_req == 1'b0, "R1", 32'(mem_req), 0, "mem_req after reset");
        check(top_offset == 0, "R1", top_offset, 0, "result after reset");
    endtask

    task automatic t_alias();
        int cyc; bit got;
        setup(32'h0, 33'h1_0000_0000, 10'h3FF, 32'hFFFF_FFFF, 1'b0);
        do_run(0, cyc, got);
        ref_cycles = cyc;
        check(got, "R8", 32'(got), 1, "done seen");
        check(top_offset == 32'h0000_0FFC, "R2", top_offset, 32'h0FFC, "4 KiB repeat");
        check(top_offset[1:0] == 2'b00, "R2", top_offset, 32'h0FFC, "word granularity");
        check(nacc == 140, "R6", 32'(nacc), 140, "access count with early stop");
        check(nwr == 80, "R5", 32'(nwr), 80, "write count");
        after_done("R8");
        repeat (20) @(negedge clk);
        check(top_offset == 32'h0FFC && !done, "R8", top_offset, 32'h0FFC, "result held idle");
    endtask

    task automatic t_region();
        int cyc; bit got;
        setup(32'h0, 33'h600, 10'h3FF, 32'hFFFF_FFFF, 1'b1);
        do_run(0, cyc, got);
        check(top_offset == 32'h5FC, "R4", top_offset, 32'h5FC, "region end 0x600");
        check(nacc == 64, "R4", 32'(nacc), 64, "no access for refused bits");
        check(bad_acc == 0, "R4", 32'(bad_acc), 0, "access outside region");
        check(nwr == 32, "R7", 32'(nwr), 32, "writes with slow ack");
        after_done("R8");
    endtask

    task automatic t_base();
        int cyc; bit got;
        setup(32'h1000_0000, 33'h800, 10'h3FF, 32'hFFFF_FFFF, 1'b0);
        do_run(0, cyc, got);
        check(top_offset == 32'h7FC, "R3", top_offset, 32'h7FC, "offset base result");
        check(bad_acc == 0, "R3", 32'(bad_acc), 0, "address off base window");
        check(nacc == 72, "R3", 32'(nacc), 72, "accesses with base");
    endtask

    task automatic t_stuck_data();
        int cyc; bit got;
        setup(32'h0, 33'h1_0000_0000, 10'h3FF, ~(32'h1 << 13), 1'b0);
        do_run(0, cyc, got);
        check(top_offset == 32'h0, "R11", top_offset, 0, "stuck data bit");
    endtask

    task automatic t_addr_alias();
        int cyc; bit got;
        setup(32'h0, 33'h1_0000_0000, 10'h3EF, 32'hFFFF_FFFF, 1'b1);
        do_run(0, cyc, got);
        check(top_offset == 32'hFBC, "R10", top_offset, 32'hFBC, "undecoded address bit 6");
    endtask

    task automatic t_busy_start();
        int cyc; bit got;
        setup(32'h0, 33'h1_0000_0000, 10'h3FF, 32'hFFFF_FFFF, 1'b0);
        do_run(57, cyc, got);
        check(cyc == ref_cycles, "R9", 32'(cyc), 32'(ref_cycles), "search length with stray start");
        check(top_offset == 32'hFFC, "R9", top_offset, 32'hFFC, "result with stray start");
        after_done("R9");
    endtask

    task automatic t_start_at_done();
        int cyc; bit got;
        setup(32'h0, 33'h1_0000_0000, 10'h3FF, 32'hFFFF_FFFF, 1'b0);
        do_run(0, cyc, got);
        check(top_offset == 32'hFFC, "R2", top_offset, 32'hFFC, "first search result");
        region_end = 33'h400;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(top_offset == 32'h0 && !done, "R9", top_offset, 0, "start in done cycle accepted");
        got = 1'b0; cyc = 0;
        while (!got && cyc < 20000) begin
            @(negedge clk); cyc++;
            if (done) got = 1'b1;
        end
        check(got, "R9", 32'(got), 1, "second done");
        check(top_offset == 32'h3FC, "R9", top_offset, 32'h3FC, "second search result");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_alias();
        t_region();
        t_base();
        t_stuck_data();
        t_addr_alias();
        t_busy_start();
        t_start_at_done();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule